// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block takes a set of level-sensitive interrupt lines from peripherals and turns them into one request line toward a processor, together with a code that identifies the source. When several lines are active together, a fixed order decides which one wins: the lowest line index has the highest priority. The block records which sources are currently being serviced. A new request is offered to the processor only when its priority is strictly above the most urgent level already in service. This lets a more urgent source interrupt a running handler, while an equal or less urgent source waits.

The processor answers a request with an acknowledge pulse. On the next cycle the block presents the winning source's code for exactly one cycle. That source's in-service bit is set at the same moment. When the processor signals end of service, the block clears the in-service bit of the most urgent active level. This brings back the level that was interrupted, and any request that was held back can then be offered. The per-source codes are a parameter, so they can hold a device address or a handler entry address.

Top module: `intc_nest`

## Requirements
- R1: After reset, `int_o` and `vec_valid_o` are 0 and no source is in service, so any enabled request can be offered.
- R2: When several active requests compete, the one with the lowest index wins, and its code is the one delivered.
- R3: A pending request whose index is equal to or greater than the lowest in-service index is not offered (`int_o` stays 0) until service ends.
- R4: A pending request whose index is strictly lower than the lowest in-service index raises `int_o` in the same cycle, without waiting for end of service.
- R5: When `ack_i` is high while `int_o` is high, `vec_valid_o` is 1 on the following cycle only. `vec_o` then holds the winner's code, which by default is 0x40 + 4*index for an 8-bit code.
- R6: An `eoi_i` pulse clears only the most urgent in-service source. Requests that the restored level allows can then be offered, and sources below it stay held.
- R7: While `gie_i` is 0, `int_o` is 0 regardless of requests.
- R8: An `ack_i` that arrives while `int_o` is 0 is ignored. No code is delivered and the in-service state does not change.
- R9: A source that is already in service does not request again while its line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_SRC | Level-sensitive request lines, index 0 most urgent |
| gie_i | input | 1 | Global enable for the processor request |
| ack_i | input | 1 | Processor accepts the current request |
| eoi_i | input | 1 | Processor has finished servicing the most urgent active level |
| int_o | output | 1 | Request to the processor |
| vec_valid_o | output | 1 | Code on `vec_o` is valid this cycle |
| vec_o | output | VEC_W | Code of the accepted source |

## Verification
The in-service mask is the only internal state that lasts across cycles, and it shows at the ports only through `int_o`. If a bit is wrongly left set, a request that should preempt stays silent. If a bit is wrongly cleared, a held request, or the serviced source itself, raises `int_o` in the very cycle that follows. The stimulus therefore runs nesting two levels deep with lower-priority lines held high, and then unwinds with end-of-service pulses. At each step, `int_o` is sampled one cycle after the mask changes, and the delivered code is checked one cycle after each accepted acknowledge.

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  oh_o
);
    // lowest set index wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_oh
        assign oh_o[g] = found_o && (idx_o == IW'(g));
    end
endmodule

// File: rtl/intc_vec_sel.sv
module intc_vec_sel #(
    parameter int N     = 8,
    parameter int W     = 8,
    parameter logic [N*W-1:0] CODES = '0,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] idx_i,
    output logic [W-1:0]  code_o
);
    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (idx_i == IW'(i)) code_o = CODES[i*W +: W];
        end
    end
endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 8,
    parameter logic [N_SRC*VEC_W-1:0] VEC_CODES = 64'h5C58_5450_4C48_4440,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_i,
    input  logic             gie_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             int_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic [N_SRC-1:0] isr;
        logic             vld;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    logic             svc_found, win_found, take;
    logic [IW-1:0]    svc_idx, win_idx;
    logic [N_SRC-1:0] svc_oh, win_oh, pend;
    logic [VEC_W-1:0] win_code;

    // a source in service cannot request again
    assign pend = irq_i & ~st_q.isr;

    intc_prio_pick #(.N(N_SRC)) u_svc (
        .req_i(st_q.isr), .found_o(svc_found), .idx_o(svc_idx), .oh_o(svc_oh)
    );

    intc_prio_pick #(.N(N_SRC)) u_win (
        .req_i(pend), .found_o(win_found), .idx_o(win_idx), .oh_o(win_oh)
    );

    intc_vec_sel #(.N(N_SRC), .W(VEC_W), .CODES(VEC_CODES)) u_vec (
        .idx_i(win_idx), .code_o(win_code)
    );

    // offer only strictly more urgent than the active level
    assign int_o = gie_i && win_found && (!svc_found || (win_idx < svc_idx));
    assign take  = ack_i && int_o;

    always_comb begin
        st_d     = st_q;
        st_d.vld = take;
        if (eoi_i) st_d.isr = st_q.isr & ~svc_oh;
        if (take) begin
            st_d.isr = st_d.isr | win_oh;
            st_d.vec = win_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_valid_o = st_q.vld;
    assign vec_o       = st_q.vec;

    // R5
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(ack_i && int_o));

    // R4
    nest_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |=> (st_q.isr != '0));

    // R6
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !take && (st_q.isr != '0)) |=>
        ($countones(st_q.isr) == $countones($past(st_q.isr)) - 1));

    // R8
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o && !eoi_i) |=> ($stable(st_q.isr) && !vec_valid_o));

    // R2
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh));
endmodule

// File: tb/sim_intc_nest.sv
module sim_intc_nest;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       gie = 1'b0, ack = 1'b0, eoi = 1'b0;
    logic       int_w, vld_w;
    logic [7:0] vec_w;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    intc_nest u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .gie_i(gie), .ack_i(ack),
        .eoi_i(eoi), .int_o(int_w), .vec_valid_o(vld_w), .vec_o(vec_w)
    );

    typedef struct packed {
        logic [7:0] irq;
        logic       gie, ack, eoi, xint, xvld;
        logic [7:0] xvec;
        logic [3:0] req;
    } row_t;

    function automatic logic [7:0] code_of(int i);
        return 8'(8'h40 + 4 * i);
    endfunction

    // irq gie ack eoi | exp int, exp vld, exp vec | requirement
    localparam row_t TBL [22] = '{
        '{8'h00,1'b1,1'b0,1'b0, 1'b0,1'b0,8'h00, 4'd1}, // R1 idle
        '{8'h28,1'b1,1'b0,1'b0, 1'b1,1'b0,8'h00, 4'd2}, // R2 src3 wins over 5
        '{8'h28,1'b1,1'b1,1'b0, 1'b1,1'b0,8'h00, 4'd5}, // R5 accept src3
        '{8'h28,1'b1,1'b0,1'b0, 1'b0,1'b1,8'h4C, 4'd3}, // R3 src5 held
        '{8'h2A,1'b1,1'b0,1'b0, 1'b1,1'b0,8'h00, 4'd4}, // R4 src1 preempts
        '{8'h2A,1'b1,1'b1,1'b0, 1'b1,1'b0,8'h00, 4'd4}, // R4 accept nested
        '{8'h2A,1'b1,1'b0,1'b0, 1'b0,1'b1,8'h44, 4'd9}, // R9 src1 silent
        '{8'h28,1'b1,1'b0,1'b1, 1'b0,1'b0,8'h00, 4'd6}, // R6 pop src1
        '{8'h28,1'b1,1'b0,1'b0, 1'b0,1'b0,8'h00, 4'd3}, // R3 src5 held at level 3
        '{8'h24,1'b1,1'b0,1'b0, 1'b1,1'b0,8'h00, 4'd6}, // R6 src2 beats level 3
        '{8'h20,1'b1,1'b0,1'b1, 1'b0,1'b0,8'h00, 4'd6}, // R6 pop src3
        '{8'h20,1'b1,1'b0,1'b0, 1'b1,1'b0,8'h00, 4'd6}, // R6 src5 released
        '{8'h20,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 4'd7}, // R7 masked
        '{8'h20,1'b0,1'b1,1'b0, 1'b0,1'b0,8'h00, 4'd8}, // R8 stray ack
        '{8'h20,1'b1,1'b0,1'b0, 1'b1,1'b0,8'h00, 4'd8}, // R8 nothing taken
        '{8'hFF,1'b1,1'b1,1'b0, 1'b1,1'b0,8'h00, 4'd2}, // R2 all lines, take src0
        '{8'hFF,1'b1,1'b0,1'b0, 1'b0,1'b1,8'h40, 4'd2}, // R2 code of src0
        '{8'h00,1'b1,1'b0,1'b1, 1'b0,1'b0,8'h00, 4'd5}, // R5 one-cycle valid
        '{8'h80,1'b1,1'b1,1'b0, 1'b1,1'b0,8'h00, 4'd2}, // R2 lone src7
        '{8'h00,1'b1,1'b0,1'b0, 1'b0,1'b1,8'h5C, 4'd5}, // R5 code of src7
        '{8'h00,1'b1,1'b0,1'b1, 1'b0,1'b0,8'h00, 4'd6}, // R6 pop src7
        '{8'h00,1'b1,1'b0,1'b0, 1'b0,1'b0,8'h00, 4'd1}  // R1 idle again
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(logic [7:0] r, logic g, logic a, logic e);
        @(negedge clk);
        irq = r; gie = g; ack = a; eoi = e;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 int", {7'd0, int_w}, 8'd0);
        chk("R1 vld", {7'd0, vld_w}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < 22; k++) begin
            drive(TBL[k].irq, TBL[k].gie, TBL[k].ack, TBL[k].eoi);
            chk($sformatf("R%0d row %0d int", TBL[k].req, k), {7'd0, int_w}, {7'd0, TBL[k].xint});
            chk($sformatf("R%0d row %0d vld", TBL[k].req, k), {7'd0, vld_w}, {7'd0, TBL[k].xvld});
            if (TBL[k].xvld)
                chk($sformatf("R%0d row %0d vec", TBL[k].req, k), vec_w, TBL[k].xvec);
        end

        // R1 reset clears in-service state mid-service
        drive(8'h08, 1'b1, 1'b1, 1'b0);
        drive(8'h20, 1'b1, 1'b0, 1'b0);
        chk("R3 src5 held under src3", {7'd0, int_w}, 8'd0);
        rst_n = 1'b0;
        drive(8'h20, 1'b1, 1'b0, 1'b0);
        chk("R1 vld in reset", {7'd0, vld_w}, 8'd0);
        rst_n = 1'b1;
        drive(8'h20, 1'b1, 1'b0, 1'b0);
        chk("R1 mask empty after reset", {7'd0, int_w}, 8'd1);

        // R5 ack and eoi in the same cycle: nested src2 accepted while src5 pops
        drive(8'h20, 1'b1, 1'b1, 1'b0);
        drive(8'h04, 1'b1, 1'b1, 1'b1);
        chk("R4 src2 over src5", {7'd0, int_w}, 8'd1);
        drive(8'h24, 1'b1, 1'b0, 1'b0);
        chk("R5 code src2", vec_w, code_of(2));
        chk("R9 src2 and popped src5", {7'd0, int_w}, 8'd0);
        drive(8'h21, 1'b1, 1'b0, 1'b0);
        chk("R4 src0 over src2", {7'd0, int_w}, 8'd1);
        drive(8'h00, 1'b1, 1'b0, 1'b1);
        drive(8'h20, 1'b1, 1'b0, 1'b0);
        chk("R6 src5 after last pop", {7'd0, int_w}, 8'd1);

        drive(8'h00, 1'b1, 1'b0, 1'b0);
        finish_run();
    end
endmodule